// File: doc/BRIEF.md
# Power-Down and Wake-Up Sequencer

This block controls how a small microcontroller enters and leaves a low-power state. Software writes a power-down request. The block then gives software a fixed grace window, measured in CPU clock cycles, in which to halt the core. At the end of that window it drives a shutdown line to the analog section, which covers the oscillator, PLL, reference and bias.

Several wake sources are OR'ed together to leave the state: eight user pins, a card interface interrupt and a keypad interrupt. Each user pin takes part only when its source code selects interrupt 0, and its polarity is set per pin. The combined wake signal releases the shutdown line at once, before any clock edge, because the clocks are stopped at that point. A synchronized copy of the wake signal then starts a long settle counter. That counter advances only while the CPU clock is reported valid. When it expires, the block raises interrupt 0 to the core and clears the request.

A routing select decides the mode. With the select high, wake sources pass through the settle path. With it low, qualified user pins drive interrupt 0 directly, and nothing can release a shutdown.

Top module: `pwr_seq_top`

## Requirements
- R1: While reset is low, and on release of reset, `analog_off`, `irq0_req` and `pd_pending` are all 0.
- R2: `analog_off` rises exactly 33 clock edges after the edge that samples `pd_set`=1. That is 32 grace cycles after `pd_pending` rises, and it is never earlier.
- R3: `pd_pending` is 1 from the edge that samples `pd_set`=1 until the settle delay completes.
- R4: The wake condition is the OR of `card_irq`, `keypad_irq` and every qualified user pin. Any single one of them releases the shutdown when `route_sel`=1.
- R5: The 3-bit source code of pin i sits at `usr_src[3i+2:3i]`. Code 4 qualifies the pin when it is high, code 6 qualifies it when it is low, and every other code leaves the pin ignored.
- R6: With `route_sel`=1, `analog_off` drops in the same cycle a wake source becomes active, with no clock edge needed.
- R7: With `clk_ok`=1 throughout, `irq0_req` rises after the 515th clock edge counted from the first edge that sees the wake active. This is two synchronizer edges, one start edge and 512 settle edges.
- R8: Each edge seen with `clk_ok`=0 during settling delays `irq0_req` by one edge.
- R9: When settling completes, `pd_pending` clears. `irq0_req` then stays 1 until an edge samples `irq_ack`=1.
- R10: With `route_sel`=0, a qualified pin sets `irq0_req` after the third edge that sees it. A shutdown is not released by any wake source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_ok | input | 1 | CPU clock valid; gates the settle counter |
| route_sel | input | 1 | 1: wake sources go through the settle path; 0: pins drive interrupt 0 directly |
| pd_set | input | 1 | Software write of 1 to the power-down request bit |
| irq_ack | input | 1 | Software acknowledge of interrupt 0 |
| usr_pin | input | NPIN | User pin levels (asynchronous) |
| usr_src | input | 3*NPIN | Per-pin source codes |
| card_irq | input | 1 | Card interface interrupt (asynchronous) |
| keypad_irq | input | 1 | Keypad interrupt (asynchronous) |
| analog_off | output | 1 | Shutdown line to the analog section |
| irq0_req | output | 1 | Interrupt 0 request to the core |
| pd_pending | output | 1 | Readback of the power-down request bit |

## Verification
The shutdown line is due 33 edges after the request strobe is sampled. Its release is combinational in the cycle the wake appears. Interrupt 0 is due 515 edges after the wake is first seen, plus one edge for each invalid-clock edge, or 3 edges in direct mode. The bench counts edges from the stimulus to the sampling point for each of these results. Stimulus changes on the falling edge and all outputs are sampled a quarter period later. On every cycle the outputs are compared with a behavioural model that is updated on the rising edge.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
   localparam int             SRC_W       = 3;
   localparam logic [SRC_W-1:0] SRC_INT0_HI = 3'd4;
   localparam logic [SRC_W-1:0] SRC_INT0_LO = 3'd6;
endpackage

// File: rtl/pwr_wake_mux.sv
module pwr_wake_mux
   import pwr_seq_pkg::*;
#(
   parameter int NPIN = 8
) (
   input  logic [NPIN-1:0]       pin,
   input  logic [SRC_W*NPIN-1:0] src,
   input  logic                  card_irq,
   input  logic                  keypad_irq,
   output logic                  pin_wake,
   output logic                  all_wake
);
   logic [NPIN-1:0] qual;

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      logic [SRC_W-1:0] code;
      assign code    = src[i*SRC_W +: SRC_W];
      assign qual[i] = ((code == SRC_INT0_HI) &  pin[i]) |
                       ((code == SRC_INT0_LO) & ~pin[i]);
   end

   assign pin_wake = |qual;
   assign all_wake = pin_wake | card_irq | keypad_irq;
endmodule

// File: rtl/pwr_sync.sv
module pwr_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) st[k] <= '0;
      end else begin
         st[0] <= d;
         for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/pwr_tc_cnt.sv
module pwr_tc_cnt #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         clr,
   output logic         tc,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (en)  cnt <= cnt + 1'b1;
   end

   assign tc = en & (&cnt);
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
   import pwr_seq_pkg::*;
#(
   parameter int NPIN        = 8,
   parameter int GRACE_W     = 5,
   parameter int SETTLE_W    = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clk_ok,
   input  logic                  route_sel,
   input  logic                  pd_set,
   input  logic                  irq_ack,
   input  logic [NPIN-1:0]       usr_pin,
   input  logic [SRC_W*NPIN-1:0] usr_src,
   input  logic                  card_irq,
   input  logic                  keypad_irq,
   output logic                  analog_off,
   output logic                  irq0_req,
   output logic                  pd_pending
);
   if (NPIN < 1 || GRACE_W < 1 || SETTLE_W < 1 || SYNC_STAGES < 2) begin : g_bad_cfg
      $error("pwr_seq_top: illegal parameter set");
   end

   logic                pin_raw, wake_raw, pin_s, wake_s;
   logic                off_q, waking_q, req_q, irq_q;
   logic                grace_en, grace_tc, settle_en, settle_tc, wake_go, irq_set;
   logic [GRACE_W-1:0]  grace_cnt;
   logic [SETTLE_W-1:0] settle_cnt;

   pwr_wake_mux #(.NPIN(NPIN)) u_mux (
      .pin(usr_pin), .src(usr_src), .card_irq(card_irq), .keypad_irq(keypad_irq),
      .pin_wake(pin_raw), .all_wake(wake_raw)
   );

   pwr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({pin_raw, wake_raw}), .q({pin_s, wake_s})
   );

   assign grace_en  = req_q & ~off_q & ~waking_q;
   assign settle_en = waking_q & clk_ok;
   assign wake_go   = route_sel & off_q & wake_s;
   assign irq_set   = settle_tc | (~route_sel & pin_s);

   pwr_tc_cnt #(.W(GRACE_W)) u_grace (
      .clk(clk), .rst_n(rst_n), .en(grace_en), .clr(settle_tc),
      .tc(grace_tc), .cnt(grace_cnt)
   );

   pwr_tc_cnt #(.W(SETTLE_W)) u_settle (
      .clk(clk), .rst_n(rst_n), .en(settle_en), .clr(1'b0),
      .tc(settle_tc), .cnt(settle_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q    <= 1'b0;
         waking_q <= 1'b0;
         req_q    <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         if (grace_tc)      off_q <= 1'b1;
         else if (wake_go)  off_q <= 1'b0;

         if (wake_go)        waking_q <= 1'b1;
         else if (settle_tc) waking_q <= 1'b0;

         if (pd_set)         req_q <= 1'b1;
         else if (settle_tc) req_q <= 1'b0;

         if (irq_set)        irq_q <= 1'b1;
         else if (irq_ack)   irq_q <= 1'b0;
      end
   end

   assign analog_off = off_q & ~(route_sel & wake_raw);
   assign irq0_req   = irq_q;
   assign pd_pending = req_q;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
   parameter int SETTLE_W = 9
) (
   input logic                clk,
   input logic                rst_n,
   input logic                clk_ok,
   input logic                route_sel,
   input logic                pd_set,
   input logic                irq_ack,
   input logic                card_irq,
   input logic                analog_off,
   input logic                irq0_req,
   input logic                pd_pending,
   input logic [SETTLE_W-1:0] settle_cnt
);
   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      irq0_req && !irq_ack |=> irq0_req); // R9
   AST_REQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      route_sel && $rose(irq0_req) && !$past(pd_set) |-> !pd_pending); // R9
   AST_OFF_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(analog_off) |-> pd_pending); // R2
   AST_CARD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      route_sel && card_irq |-> !analog_off); // R6
   AST_SETTLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_ok |=> $stable(settle_cnt)); // R8
endmodule

bind pwr_seq_top pwr_seq_chk #(.SETTLE_W(SETTLE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clk_ok(clk_ok), .route_sel(route_sel),
   .pd_set(pd_set), .irq_ack(irq_ack), .card_irq(card_irq),
   .analog_off(analog_off), .irq0_req(irq0_req), .pd_pending(pd_pending),
   .settle_cnt(settle_cnt)
);

// File: tb/sim_pwr_seq_top.sv
module sim_pwr_seq_top;
   localparam int CLK_P = 10;
   localparam int NPIN  = 8;
   localparam int GMAX  = 31;
   localparam int SMAX  = 511;

   logic clk = 1'b0, rst_n = 1'b0, clk_ok = 1'b1, route_sel = 1'b0;
   logic pd_set = 1'b0, irq_ack = 1'b0, card_irq = 1'b0, keypad_irq = 1'b0;
   logic [NPIN-1:0]   usr_pin = '0;
   logic [3*NPIN-1:0] usr_src = '0;
   logic analog_off, irq0_req, pd_pending;

   int checks = 0, failures = 0;
   bit running = 0;
   string cur_req = "R1";

   always #(CLK_P/2) clk = ~clk;

   pwr_seq_top u0 (
      .clk(clk), .rst_n(rst_n), .clk_ok(clk_ok), .route_sel(route_sel),
      .pd_set(pd_set), .irq_ack(irq_ack), .usr_pin(usr_pin), .usr_src(usr_src),
      .card_irq(card_irq), .keypad_irq(keypad_irq),
      .analog_off(analog_off), .irq0_req(irq0_req), .pd_pending(pd_pending)
   );

   function automatic bit pin_q();
      for (int i = 0; i < NPIN; i++) begin
         if (usr_src[3*i +: 3] == 3'd4 &&  usr_pin[i]) return 1;
         if (usr_src[3*i +: 3] == 3'd6 && !usr_pin[i]) return 1;
      end
      return 0;
   endfunction

   function automatic bit any_wake();
      return pin_q() || card_irq || keypad_irq;
   endfunction

   // behavioural reference model
   bit m_req, m_off, m_wk, m_irq, m_h0, m_h1, m_p0, m_p1;
   int m_g, m_s;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_req = 0; m_off = 0; m_wk = 0; m_irq = 0;
         m_h0 = 0; m_h1 = 0; m_p0 = 0; m_p1 = 0; m_g = 0; m_s = 0;
      end else begin
         bit done, n_off, n_wk, n_req, n_irq;
         int n_g, n_s;
         done  = m_wk && clk_ok && (m_s == SMAX);
         n_off = m_off; n_wk = m_wk; n_req = m_req; n_g = m_g; n_s = m_s;
         if (done || (!route_sel && m_p1)) n_irq = 1;
         else if (irq_ack)                 n_irq = 0;
         else                              n_irq = m_irq;
         if (m_req && !m_off && !m_wk) begin
            if (m_g == GMAX) begin n_off = 1; n_g = 0; end
            else n_g = m_g + 1;
         end
         if (route_sel && m_off && m_h1) begin n_off = 0; n_wk = 1; end
         if (m_wk && clk_ok) begin
            if (m_s == SMAX) begin n_s = 0; n_wk = 0; n_req = 0; n_g = 0; end
            else n_s = m_s + 1;
         end
         if (pd_set) n_req = 1;
         m_h1 = m_h0; m_h0 = any_wake();
         m_p1 = m_p0; m_p0 = pin_q();
         m_off = n_off; m_wk = n_wk; m_req = n_req; m_irq = n_irq; m_g = n_g; m_s = n_s;
      end
   end

   task automatic chk(string r, logic act, logic exp, string what);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%b expected=%b t=%0t", r, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      #(CLK_P/4);
      if (running) begin
         chk(cur_req, analog_off, rst_n && m_off && !(route_sel && any_wake()), "model analog_off");
         chk(cur_req, irq0_req,   rst_n && m_irq, "model irq0_req");
         chk(cur_req, pd_pending, rst_n && m_req, "model pd_pending");
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pd_pulse();
      pd_set = 1; step(1); pd_set = 0;
   endtask

   task automatic ack();
      irq_ack = 1; step(1); irq_ack = 0;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(CLK_P*100000);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      step(3); running = 1;
      #1 chk("R1", analog_off, 0, "reset"); chk("R1", irq0_req, 0, "reset"); chk("R1", pd_pending, 0, "reset");
      rst_n = 1; step(2);
      #1 chk("R1", pd_pending, 0, "after reset");

      // route through settle path
      cur_req = "R2"; route_sel = 1; step(1);
      pd_pulse();
      #1 chk("R3", pd_pending, 1, "request bit set");
      step(31); #1 chk("R2", analog_off, 0, "before grace end");
      step(1);  #1 chk("R2", analog_off, 1, "at grace end");
      step(5);
      cur_req = "R5";
      usr_pin[0] = 1; step(1); usr_src[2:0] = 3'd5; step(10);
      #1 chk("R5", analog_off, 1, "code 5 ignored");
      usr_src[2:0] = 3'd6; step(5);
      #1 chk("R5", analog_off, 1, "code 6 pin high inactive");
      cur_req = "R7"; usr_pin[0] = 0;
      #1 chk("R6", analog_off, 0, "immediate release");
      step(514); #1 chk("R7", irq0_req, 0, "before settle end");
      step(1);   #1 chk("R7", irq0_req, 1, "settle end");
      chk("R9", pd_pending, 0, "request cleared");
      cur_req = "R9"; step(5); #1 chk("R9", irq0_req, 1, "held");
      ack(); #1 chk("R9", irq0_req, 0, "acknowledged");
      usr_pin[0] = 1; step(1); usr_src[2:0] = 3'd0; usr_pin[0] = 0; step(3);

      // keypad wake with clock-valid pause
      cur_req = "R8"; pd_pulse(); step(40);
      keypad_irq = 1;
      #1 chk("R4", analog_off, 0, "keypad releases");
      step(3); clk_ok = 0; step(20); clk_ok = 1; keypad_irq = 0;
      step(511); #1 chk("R8", irq0_req, 0, "paused settle");
      step(1);   #1 chk("R8", irq0_req, 1, "paused settle end");
      ack(); step(3);

      // active-high pin wake
      cur_req = "R4"; usr_src[8:6] = 3'd4; pd_pulse(); step(40);
      #1 chk("R4", analog_off, 1, "down before pin");
      usr_pin[2] = 1;
      #1 chk("R4", analog_off, 0, "pin code 4 releases");
      step(520); usr_pin[2] = 0; ack(); step(3);
      #1 chk("R4", irq0_req, 0, "cleared");

      // direct routing
      cur_req = "R10"; rst_n = 0; route_sel = 0; usr_src = '0; step(2); rst_n = 1; step(2);
      usr_src[5:3] = 3'd4; step(1); usr_pin[1] = 1;
      step(2); #1 chk("R10", irq0_req, 0, "direct before");
      step(1); #1 chk("R10", irq0_req, 1, "direct after 3 edges");
      usr_pin[1] = 0; step(3); ack();
      #1 chk("R10", irq0_req, 0, "direct ack");
      pd_pulse(); step(40); card_irq = 1; step(600);
      #1 chk("R10", analog_off, 1, "no wake in direct mode");
      chk("R10", irq0_req, 0, "no irq from card");
      card_irq = 0; step(2);
      finish_run();
   end
endmodule